// File: doc/BRIEF.md
# Converter Start-and-Read Sequencer

This block runs on the host side of an external sampling converter. It drives the active-low start line, follows the converter's busy handshake, and fetches each 16-bit result over an 8-bit lane as two byte reads. A byte-select line acts as an address bit that picks which half of the result appears on the lane. When both bytes are in, the block presents the assembled word together with a one-cycle valid strobe.

Conversions are started by a one-cycle request or run back to back under a free-run enable. A mode input chooses when the result is fetched. In read-after mode the block reads the word once busy has dropped, so each strobe carries the conversion that has just ended. In read-during mode the block reads the stored word of the previous conversion while the next one runs, and it ends the read well inside the first half of the conversion time.

Top module: `adc_read_seq`

## Requirements
- R1: A start is a low pulse on `cnvst_n` lasting exactly START_LOW clocks. Nothing is started after reset until a request (`start_req` or `free_run` high) is seen.
- R2: A start is issued only while `busy` is low and only from the idle state, so `cnvst_n` never falls while a conversion runs.
- R3: With `read_during` = 0 when the start was issued, the read begins only after `busy` has fallen, and the word delivered is that conversion's result.
- R4: With `read_during` = 1, the stored word of the previous conversion is read while `busy` is high, and `rd_n` is back high in fewer than CONV_CLKS/2 clocks after `cnvst_n` fell. The first such conversion after reset, or after a read-after conversion, performs no read.
- R5: `rd_n` is low only while `cs_n` is low, and `cs_n` is high outside a read sequence.
- R6: A read is two strobes on `rd_n`, each exactly RD_CLKS clocks low. The first has `byte_sel` = 0 (low byte, bits 7:0) and the second has `byte_sel` = 1 (high byte, bits 15:8). Exactly one clock with `rd_n` high separates them, and `din` is sampled on the last low clock of each strobe.
- R7: `result_valid` pulses high for exactly one clock after the high byte is sampled. `result` then equals {high byte, low byte} and holds until the next pulse.
- R8: During reset, `cnvst_n`, `cs_n` and `rd_n` are high, `byte_sel` is 0, `result_valid` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | Request one conversion |
| free_run | input | 1 | Start conversions back to back while high |
| read_during | input | 1 | 1: read the previous word during the next conversion; 0: read after the conversion |
| busy | input | 1 | High while the converter is converting |
| din | input | 8 | Byte lane from the converter |
| cnvst_n | output | 1 | Active-low conversion start |
| cs_n | output | 1 | Active-low chip select |
| rd_n | output | 1 | Active-low read strobe |
| byte_sel | output | 1 | Byte address: 0 low byte, 1 high byte |
| result | output | 16 | Last assembled result |
| result_valid | output | 1 | One-cycle strobe for a new result |

## Verification
Single requests in read-after mode show that every word is fetched after busy drops and matches the conversion just ended. Free-running read-during mode checks that each word is one conversion behind, that the first conversion reads nothing, and that each read ends inside the first half of the conversion window. Switching from read-after back to read-during with requests shows that the pending-data state resets, because one fewer word than conversions comes out. A behavioural converter model returns a different word per conversion and drives a junk byte whenever the lane is not enabled, so swapped bytes, late samples and reads without select all show up as value mismatches.

// File: rtl/adc_read_seq.sv
module adc_read_seq #(
  parameter int CONV_CLKS = 40,
  parameter int START_LOW = 2,
  parameter int RD_CLKS   = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_req,
  input  logic        free_run,
  input  logic        read_during,
  input  logic        busy,
  input  logic [7:0]  din,
  output logic        cnvst_n,
  output logic        cs_n,
  output logic        rd_n,
  output logic        byte_sel,
  output logic [15:0] result,
  output logic        result_valid
);
  localparam int CMAX = (START_LOW > RD_CLKS) ? START_LOW : RD_CLKS;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int SW   = $clog2(CONV_CLKS + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_WAIT_HI, S_RD_LO, S_GAP, S_RD_HI, S_WAIT_LO} st_t;
  st_t st;

  logic [CW-1:0] cnt;
  logic [SW-1:0] since;
  logic          mode_q, have_prev;
  logic [7:0]    lo_q;

  wire go      = (start_req | free_run) & ~busy;
  wire st_last = cnt == CW'(START_LOW - 1);
  wire rd_last = cnt == CW'(RD_CLKS - 1);

  assign cnvst_n  = st != S_START;
  assign rd_n     = !(st == S_RD_LO || st == S_RD_HI);
  assign cs_n     = !(st == S_RD_LO || st == S_GAP || st == S_RD_HI);
  assign byte_sel = st == S_GAP || st == S_RD_HI;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      since <= '0;
      mode_q <= 1'b0;
      have_prev <= 1'b0;
      lo_q <= '0;
      result <= '0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      if (since != SW'(CONV_CLKS)) since <= since + 1'b1;
      case (st)
        S_IDLE: if (go) begin
          st <= S_START;
          cnt <= '0;
          since <= '0;
          mode_q <= read_during;
        end
        S_START: if (st_last) st <= S_WAIT_HI; else cnt <= cnt + 1'b1;
        S_WAIT_HI: if (busy) begin
          cnt <= '0;
          st <= (mode_q && have_prev) ? S_RD_LO : S_WAIT_LO;
        end
        S_WAIT_LO: if (!busy) begin
          cnt <= '0;
          have_prev <= mode_q;
          st <= mode_q ? S_IDLE : S_RD_LO;
        end
        S_RD_LO: if (rd_last) begin
          lo_q <= din;
          st <= S_GAP;
        end else cnt <= cnt + 1'b1;
        S_GAP: begin
          cnt <= '0;
          st <= S_RD_HI;
        end
        S_RD_HI: if (rd_last) begin
          result <= {din, lo_q};
          result_valid <= 1'b1;
          st <= mode_q ? S_WAIT_LO : S_IDLE;
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_no_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnvst_n) |-> !$past(busy));
  p_rd_needs_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !cs_n);
  p_sel_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && $past(!rd_n)) |-> $stable(byte_sel));
  p_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(byte_sel) |-> (rd_n && !cs_n));
  p_first_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && !rd_n) |-> (since < SW'(CONV_CLKS / 2)));
  p_read_after_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && !rd_n) |-> !busy);
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);
endmodule

// File: tb/adc_read_seq_test.sv
module adc_read_seq_test;
  localparam int CONV = 40, SL = 2, RC = 3;
  logic clk = 0, rst_n = 0;
  logic start_req = 0, free_run = 0, read_during = 0, busy = 0;
  logic [7:0] din;
  logic cnvst_n, cs_n, rd_n, byte_sel, result_valid;
  logic [15:0] result;

  adc_read_seq #(.CONV_CLKS(CONV), .START_LOW(SL), .RD_CLKS(RC)) uut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .free_run(free_run),
    .read_during(read_during), .busy(busy), .din(din), .cnvst_n(cnvst_n),
    .cs_n(cs_n), .rd_n(rd_n), .byte_sel(byte_sel), .result(result),
    .result_valid(result_valid));

  always #4 clk = ~clk;

  integer checks = 0, failures = 0;
  bit done = 0;
  logic [15:0] data_reg = 16'h0000, sample = 16'h1234;
  logic [15:0] exp_q[$];
  integer ccount = 0;

  assign din = (!cs_n && !rd_n) ? (byte_sel ? data_reg[15:8] : data_reg[7:0]) : 8'h5A;

  task automatic chk(input bit ok, input string req, input integer act, input integer exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // converter model
  always @(negedge clk) begin
    if (!rst_n) begin
      busy <= 0;
      ccount <= 0;
    end else if (!busy && !cnvst_n) begin
      busy <= 1;
      ccount <= CONV;
    end else if (busy) begin
      if (ccount == 1) begin
        busy <= 0;
        data_reg <= sample;
        exp_q.push_back(sample);
        sample <= sample * 16'h6255 + 16'h3619;
      end
      ccount <= ccount - 1;
    end
  end

  // per-clock reference comparison
  integer starts = 0, valids = 0, low_len = 0, rd_len = 0, gap_len = 0, since_start = 0;
  bit prev_cn = 1, prev_rd = 1, prev_v = 0, second = 0;
  always @(negedge clk) if (rst_n) begin
    since_start++;
    if (!cnvst_n) low_len++;
    if (prev_cn && !cnvst_n) begin
      starts++;
      since_start = 0;
      chk(busy == 0, "R2 start while busy", busy, 0);
    end
    if (!prev_cn && cnvst_n) begin
      chk(low_len == SL, "R1 start width", low_len, SL);
      low_len = 0;
    end
    if (!rd_n && cs_n) chk(0, "R5 rd without cs", cs_n, 0);
    if (!rd_n) rd_len++;
    if (rd_n && !cs_n) gap_len++;
    if (prev_rd && !rd_n) begin
      chk(byte_sel == second, "R6 byte order", byte_sel, second);
      if (second) chk(gap_len == 1, "R6 gap", gap_len, 1);
      if (!second && !read_during) chk(busy == 0, "R3 read after busy", busy, 0);
      if (read_during) chk(busy == 1, "R4 read during busy", busy, 1);
    end
    if (!prev_rd && rd_n) begin
      chk(rd_len == RC, "R6 strobe width", rd_len, RC);
      rd_len = 0;
      if (second) begin
        gap_len = 0;
        if (read_during) chk(since_start < CONV / 2, "R4 first half", since_start, CONV / 2);
      end
      second = !second;
    end
    if (result_valid) begin
      valids++;
      if (exp_q.size() == 0) chk(0, "R7 unexpected valid", result, 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(result == e, read_during ? "R4 R7 result" : "R3 R7 result", result, e);
      end
    end
    if (prev_v) chk(!result_valid, "R7 one-cycle valid", result_valid, 0);
    if (!prev_v && !result_valid && valids > 0 && exp_q.size() == 0) ;
    prev_cn = cnvst_n; prev_rd = rd_n; prev_v = result_valid;
  end

  task automatic pulse_req();
    start_req = 1;
    while (cnvst_n) @(negedge clk);
    start_req = 0;
  endtask

  task automatic phase_end(input integer exp_v, input string tag);
    repeat (120) @(negedge clk);
    chk(valids == exp_v, tag, valids, exp_v);
    exp_q.delete();
    starts = 0; valids = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cnvst_n && cs_n && rd_n && !byte_sel && !result_valid, "R8 reset pins",
        {cnvst_n, cs_n, rd_n, byte_sel, result_valid}, 5'b11100);
    chk(result == 0, "R8 reset result", result, 0);
    rst_n = 1;
    repeat (20) @(negedge clk);
    chk(starts == 0, "R1 no start without request", starts, 0);
    // read-after, single requests
    read_during = 0;
    for (int i = 0; i < 3; i++) begin
      pulse_req();
      repeat (70) @(negedge clk);
    end
    phase_end(3, "R3 valid count");
    // read-during, free run
    read_during = 1;
    free_run = 1;
    while (starts < 6) @(negedge clk);
    free_run = 0;
    phase_end(5, "R4 valid count free run");
    // read-after, free run
    read_during = 0;
    free_run = 1;
    while (starts < 4) @(negedge clk);
    free_run = 0;
    phase_end(4, "R3 valid count free run");
    // read-during after read-after: first conversion reads nothing
    read_during = 1;
    pulse_req();
    repeat (60) @(negedge clk);
    pulse_req();
    phase_end(1, "R4 no read on first during");
    chk(cnvst_n && cs_n && rd_n, "R5 idle pins", {cnvst_n, cs_n, rd_n}, 3'b111);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule